// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block decides when a simple 32-bit processor leaves its current program to service a device interrupt, and it performs the status swap for that switch. Each device drives its own request line. A request is accepted only at an instruction boundary. Two conditions must also hold: the global enable bit in the status word must be set, and the device's bit in the enable mask must be set. When a request is accepted, the block raises a one-cycle take pulse and redirects the program counter to a fixed service-entry address. In the same step it stores the address of the next instruction as the return address, copies the whole status word into a single shadow register, and clears the global enable bit.

A return-from-interrupt strobe copies the shadow back into the status word, which sets the enable bit again. The same strobe redirects the program counter to the stored return address. Software reaches the control registers only through a dedicated move-control port. The port selects one register with a 2-bit code: 0 for the status word, 1 for the shadow, 2 for the enable mask, and 3 for the pending view, which is the live request lines and is read-only. Instruction decode, the datapath and stack handling sit outside this block.

Top module: `irq_entry_ctrl`

## Requirements
- R1: `take_irq` can be high only in a cycle with `insn_done` high. From the next cycle, `ret_pc` holds the `next_pc` value that was presented in the take cycle.
- R2: In a take cycle, `pc_load` is 1 and `pc_target` equals ENTRY_ADDR. At the following edge, the shadow register receives the whole status word, and the status word keeps all of its bits except bit 0 (the enable bit), which is cleared.
- R3: A cycle with `rfi` high drives `pc_load` to 1 and `pc_target` to `ret_pc`. At the following edge, the status word takes the shadow's value. No interrupt is taken in an `rfi` cycle.
- R4: While status bit 0 is 0, no request is taken.
- R5: Bit i of the request lines, of the enable mask and of the pending view all belong to device i. A request is taken only if some bit i is set in both the request lines and the mask. For example, a mask of 6 enables devices 1 and 2 only.
- R6: Reading select code 3 returns the current request lines, whatever the mask and the enable bit are. A write with select code 3 changes no register.
- R7: A move-control write with select 0, 1 or 2 updates the status word, the shadow or the mask at the next edge. `cr_rdata` shows the selected register in the same cycle.
- R8: A status or shadow write made in a take cycle is lost to the entry swap. A status write made in an `rfi` cycle is lost to the restore.
- R9: `take_irq` never stays high for two cycles in a row.
- R10: After reset, the status word, shadow, mask and return address are 0, and `take_irq` and `pc_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | NDEV | Device request lines, one per device |
| insn_done | input | 1 | Current instruction completes this cycle |
| next_pc | input | XLEN | Address of the instruction after the current one |
| rfi | input | 1 | Return-from-interrupt executes this cycle |
| cr_sel | input | 2 | Control register select (0 status, 1 shadow, 2 mask, 3 pending) |
| cr_wr | input | 1 | Move-control write strobe |
| cr_wdata | input | XLEN | Move-control write data |
| cr_rdata | output | XLEN | Move-control read data for the selected register |
| take_irq | output | 1 | One-cycle pulse when an interrupt is accepted |
| pc_load | output | 1 | The program counter must be loaded with pc_target |
| pc_target | output | XLEN | Entry address on a take, return address on rfi |
| ret_pc | output | XLEN | Saved return address |

## Verification
The assertions assume that `rfi` is raised only while a return address has been captured. This matters because the restore check compares the status word only with the previous shadow value. They also assume that `dev_req` and the move-control inputs stay steady across each edge, and that reset is held through the first clock edges. The stimulus changes every input on the falling edge only. It asserts `rfi` only after a completed entry, or after the shadow has been loaded with a known value through the port. It holds reset low for several cycles before any strobe.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned IE_BIT = 0;
  localparam logic [1:0] SEL_STATUS  = 2'd0;
  localparam logic [1:0] SEL_SHADOW  = 2'd1;
  localparam logic [1:0] SEL_MASK    = 2'd2;
  localparam logic [1:0] SEL_PENDING = 2'd3;
endpackage

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int unsigned NDEV = 32
) (
  input  logic [NDEV-1:0] dev_req,
  input  logic [NDEV-1:0] mask_q,
  input  logic            ie,
  input  logic            insn_done,
  input  logic            rfi,
  output logic [NDEV-1:0] hit_vec,
  output logic            take
);
  function automatic logic [NDEV-1:0] masked_hits(input logic [NDEV-1:0] r,
                                                   input logic [NDEV-1:0] m);
    return r & m;
  endfunction

  logic any_hit;

  always_comb begin
    hit_vec = masked_hits(dev_req, mask_q);
    any_hit = |hit_vec;
    take    = insn_done & ~rfi & ie & any_hit;
  end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_entry_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            rfi,
  input  logic            wr_status,
  input  logic            wr_shadow,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] ps_q,
  output logic [XLEN-1:0] ips_q
);
  function automatic logic [XLEN-1:0] entry_status(input logic [XLEN-1:0] s);
    logic [XLEN-1:0] r;
    r = s;
    r[IE_BIT] = 1'b0;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      ips_q <= '0;
    end else if (take) begin
      ips_q <= ps_q;
      ps_q  <= entry_status(ps_q);
    end else if (rfi) begin
      ps_q <= ips_q;
      if (wr_shadow) ips_q <= wdata;
    end else begin
      if (wr_status) ps_q  <= wdata;
      if (wr_shadow) ips_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NDEV = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NDEV-1:0] wdata,
  output logic [NDEV-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (wr) mask_q <= wdata;
  end
endmodule

// File: rtl/irq_ret_pc.sv
module irq_ret_pc #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] ret_pc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ret_pc_q <= '0;
    else if (take) ret_pc_q <= next_pc;
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned NDEV       = 32,
  parameter int unsigned XLEN       = 32,
  parameter logic [31:0] ENTRY_ADDR = 32'h0000_0040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_req,
  input  logic            insn_done,
  input  logic [XLEN-1:0] next_pc,
  input  logic            rfi,
  input  logic [1:0]      cr_sel,
  input  logic            cr_wr,
  input  logic [XLEN-1:0] cr_wdata,
  output logic [XLEN-1:0] cr_rdata,
  output logic            take_irq,
  output logic            pc_load,
  output logic [XLEN-1:0] pc_target,
  output logic [XLEN-1:0] ret_pc
);
  localparam logic [XLEN-1:0] ENTRY_PC = XLEN'(ENTRY_ADDR);

  logic [XLEN-1:0] ps_q, ips_q, ret_pc_q;
  logic [NDEV-1:0] mask_q, hit_vec;
  logic            take;
  logic            wr_status, wr_shadow, wr_mask;
  logic [XLEN-1:0] mask_ext, pend_ext;

  always_comb begin
    wr_status = cr_wr && (cr_sel == SEL_STATUS);
    wr_shadow = cr_wr && (cr_sel == SEL_SHADOW);
    wr_mask   = cr_wr && (cr_sel == SEL_MASK);
  end

  irq_accept #(.NDEV(NDEV)) u_accept (
    .dev_req  (dev_req),
    .mask_q   (mask_q),
    .ie       (ps_q[IE_BIT]),
    .insn_done(insn_done),
    .rfi      (rfi),
    .hit_vec  (hit_vec),
    .take     (take)
  );

  irq_status_regs #(.XLEN(XLEN)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .rfi      (rfi),
    .wr_status(wr_status),
    .wr_shadow(wr_shadow),
    .wdata    (cr_wdata),
    .ps_q     (ps_q),
    .ips_q    (ips_q)
  );

  irq_mask_reg #(.NDEV(NDEV)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_mask),
    .wdata (cr_wdata[NDEV-1:0]),
    .mask_q(mask_q)
  );

  irq_ret_pc #(.XLEN(XLEN)) u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .next_pc (next_pc),
    .ret_pc_q(ret_pc_q)
  );

  always_comb begin
    mask_ext = '0;
    pend_ext = '0;
    mask_ext[NDEV-1:0] = mask_q;
    pend_ext[NDEV-1:0] = dev_req;
    unique case (cr_sel)
      SEL_STATUS: cr_rdata = ps_q;
      SEL_SHADOW: cr_rdata = ips_q;
      SEL_MASK:   cr_rdata = mask_ext;
      default:    cr_rdata = pend_ext;
    endcase
  end

  always_comb begin
    take_irq  = take;
    pc_load   = take | rfi;
    pc_target = take ? ENTRY_PC : ret_pc_q;
    ret_pc    = ret_pc_q;
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int unsigned NDEV       = 32,
  parameter int unsigned XLEN       = 32,
  parameter logic [31:0] ENTRY_ADDR = 32'h0000_0040
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_irq,
  input logic            insn_done,
  input logic            rfi,
  input logic [NDEV-1:0] dev_req,
  input logic [NDEV-1:0] mask_q,
  input logic [XLEN-1:0] ps_q,
  input logic [XLEN-1:0] ips_q,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] ret_pc,
  input logic            pc_load,
  input logic [XLEN-1:0] pc_target,
  input logic            cr_wr,
  input logic [1:0]      cr_sel
);
  a_r1_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> insn_done);
  a_r1_ret_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> ret_pc == $past(next_pc));
  a_r2_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (pc_load && pc_target == XLEN'(ENTRY_ADDR)));
  a_r2_swap: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (ips_q == $past(ps_q) && ps_q == ($past(ps_q) & ~XLEN'(1))));
  a_r3_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rfi |=> ps_q == $past(ips_q));
  a_r3_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    rfi |-> (!take_irq && pc_load && pc_target == ret_pc));
  a_r4_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_q[0] |-> !take_irq);
  a_r5_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (|(dev_req & mask_q)));
  a_r8_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && cr_wr && cr_sel != 2'd2 && cr_sel != 2'd3) |=> !ps_q[0]);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq);
endmodule

bind irq_entry_ctrl irq_entry_chk #(.NDEV(NDEV), .XLEN(XLEN), .ENTRY_ADDR(ENTRY_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .insn_done(insn_done), .rfi(rfi),
  .dev_req(dev_req), .mask_q(mask_q), .ps_q(ps_q), .ips_q(ips_q), .next_pc(next_pc),
  .ret_pc(ret_pc), .pc_load(pc_load), .pc_target(pc_target), .cr_wr(cr_wr), .cr_sel(cr_sel)
);

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;
  localparam logic [31:0] ENTRY = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dev_req = '0;
  logic        insn_done = 1'b0;
  logic [31:0] next_pc = '0;
  logic        rfi = 1'b0;
  logic [1:0]  cr_sel = 2'd0;
  logic        cr_wr = 1'b0;
  logic [31:0] cr_wdata = '0;
  logic [31:0] cr_rdata, pc_target, ret_pc;
  logic        take_irq, pc_load;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_entry_ctrl #(.NDEV(32), .XLEN(32), .ENTRY_ADDR(ENTRY)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .insn_done(insn_done),
    .next_pc(next_pc), .rfi(rfi), .cr_sel(cr_sel), .cr_wr(cr_wr),
    .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .take_irq(take_irq),
    .pc_load(pc_load), .pc_target(pc_target), .ret_pc(ret_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    cr_sel = sel;
    #1 v = cr_rdata;
  endtask

  task automatic cr_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cr_sel = sel; cr_wdata = d; cr_wr = 1'b1;
    @(negedge clk);
    cr_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R10 take", {31'd0, take_irq}, 32'd0);
    chk("R10 pc_load", {31'd0, pc_load}, 32'd0);
    chk("R10 ret_pc", ret_pc, 32'd0);
    rd(2'd0, v); chk("R10 status", v, 32'd0);
    rd(2'd1, v); chk("R10 shadow", v, 32'd0);
    rd(2'd2, v); chk("R10 mask", v, 32'd0);
  endtask

  task automatic t_ie_gate;
    logic [31:0] v;
    cr_write(2'd2, 32'd6);
    @(negedge clk);
    dev_req = 32'd2; insn_done = 1'b1;
    #1 chk("R4 no take with enable clear", {31'd0, take_irq}, 32'd0);
    chk("R4 no redirect", {31'd0, pc_load}, 32'd0);
    rd(2'd3, v); chk("R6 pending view", v, 32'd2);
    @(negedge clk);
    insn_done = 1'b0; dev_req = '0;
  endtask

  task automatic t_mask_gate;
    cr_write(2'd0, 32'h0000_00F1);
    @(negedge clk);
    insn_done = 1'b1; dev_req = 32'd1;
    #1 chk("R5 device 0 masked", {31'd0, take_irq}, 32'd0);
    dev_req = 32'd8;
    #1 chk("R5 device 3 masked", {31'd0, take_irq}, 32'd0);
    insn_done = 1'b0; dev_req = 32'd4;
    #1 chk("R1 no take off boundary", {31'd0, take_irq}, 32'd0);
    @(negedge clk);
    dev_req = '0;
  endtask

  task automatic t_entry;
    logic [31:0] v;
    @(negedge clk);
    dev_req = 32'd4; insn_done = 1'b1; next_pc = 32'h0000_1234;
    #1 chk("R2 take", {31'd0, take_irq}, 32'd1);
    chk("R2 pc_load", {31'd0, pc_load}, 32'd1);
    chk("R2 target", pc_target, ENTRY);
    @(negedge clk);
    chk("R9 single pulse", {31'd0, take_irq}, 32'd0);
    chk("R1 return address", ret_pc, 32'h0000_1234);
    rd(2'd0, v); chk("R2 status after entry", v, 32'h0000_00F0);
    rd(2'd1, v); chk("R2 shadow after entry", v, 32'h0000_00F1);
    insn_done = 1'b0; next_pc = '0;
  endtask

  task automatic t_return;
    logic [31:0] v;
    @(negedge clk);
    rfi = 1'b1; insn_done = 1'b1;
    #1 chk("R3 redirect", {31'd0, pc_load}, 32'd1);
    chk("R3 target", pc_target, 32'h0000_1234);
    @(negedge clk);
    rd(2'd0, v); chk("R3 status restored", v, 32'h0000_00F1);
    #1 chk("R3 no take during rfi", {31'd0, take_irq}, 32'd0);
    rfi = 1'b0;
    #1 chk("R2 take after rfi", {31'd0, take_irq}, 32'd1);
    @(negedge clk);
    insn_done = 1'b0; dev_req = '0;
  endtask

  task automatic t_conflict;
    logic [31:0] v;
    cr_write(2'd0, 32'h0000_0F01);
    @(negedge clk);
    insn_done = 1'b1; dev_req = 32'd2;
    cr_sel = 2'd0; cr_wdata = 32'hAAAA_AAAB; cr_wr = 1'b1;
    @(negedge clk);
    cr_wr = 1'b0; insn_done = 1'b0;
    rd(2'd0, v); chk("R8 status write lost on entry", v, 32'h0000_0F00);
    rd(2'd1, v); chk("R8 shadow from entry", v, 32'h0000_0F01);
    cr_write(2'd0, 32'h0000_0011);
    @(negedge clk);
    insn_done = 1'b1;
    cr_sel = 2'd1; cr_wdata = 32'hDEAD_0000; cr_wr = 1'b1;
    @(negedge clk);
    cr_wr = 1'b0; insn_done = 1'b0; dev_req = '0;
    rd(2'd1, v); chk("R8 shadow write lost on entry", v, 32'h0000_0011);
    @(negedge clk);
    rfi = 1'b1;
    cr_sel = 2'd0; cr_wdata = 32'h5555_5555; cr_wr = 1'b1;
    @(negedge clk);
    rfi = 1'b0; cr_wr = 1'b0;
    rd(2'd0, v); chk("R8 status write lost on rfi", v, 32'h0000_0011);
  endtask

  task automatic t_port;
    logic [31:0] v;
    cr_write(2'd2, 32'h8000_0001);
    rd(2'd2, v); chk("R7 mask readback", v, 32'h8000_0001);
    cr_write(2'd1, 32'h1234_5678);
    rd(2'd1, v); chk("R7 shadow readback", v, 32'h1234_5678);
    dev_req = 32'h8000_0000;
    cr_write(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R6 pending write ignored mask", v, 32'h8000_0001);
    rd(2'd0, v); chk("R6 pending write ignored status", v, 32'h0000_0011);
    rd(2'd3, v); chk("R6 pending shows lines", v, 32'h8000_0000);
    @(negedge clk);
    insn_done = 1'b1;
    #1 chk("R5 top device taken", {31'd0, take_irq}, 32'd1);
    @(negedge clk);
    insn_done = 1'b0; dev_req = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ie_gate;
    t_mask_gate;
    t_entry;
    t_return;
    t_conflict;
    t_port;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule